// File: doc/BRIEF.md
# Audio link status and interrupt register

This block is the status and interrupt-control register pair that sits beside a biphase-coded digital audio receiver and transmitter. One-cycle event pulses from the receiver latch four sticky flags: a bad or missing preamble, a block-start preamble, a complete channel-status block, and a valid user-data unit. Each flag stays set until software writes a 1 to its bit in the status register. The other status bits are live levels: two FIFO error conditions and four FIFO attention flags. Two busy flags are derived from the enables and from frame-end, lock and idle indications.

The control register holds a receive enable, a transmit enable, a loopback bit, and ten interrupt enables. Each interrupt enable sits at the same position as the status bit it gates. A single registered interrupt line is the OR of every enabled status source. Access is a simple port: `bus_sel` picks the register (0 = control, 1 = status), a write lands on the rising edge when `bus_wr` is high, and `bus_rdata` shows the selected register combinationally. The audio data path is not part of this block.

Top module: `audio_stat_regs`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0 while all level inputs are 0, and `irq` is 0.
- R2: An event pulse sets its sticky flag at the next clock edge, and the flag then holds with no further pulse. Status positions: bad preamble at bit 23, block-start preamble at 22, block complete at 21, user unit at 20.
- R3: A status write clears exactly those sticky flags whose bit in `bus_wdata` is 1. Flags written with 0 keep their value.
- R4: When an event pulse and a clearing write hit the same flag in one cycle, the flag ends set.
- R5: The level bits follow their inputs in the same cycle: TX underrun at status bit 25, RX overrun at 24, and the attention flags at 19..16 (RX user, TX user, RX data, TX data). Writes to these bits and to the busy bits have no effect.
- R6: Writable control bits are 29 (RX enable), 28 (TX enable), 25..16 (interrupt enables) and 15 (loopback). They read back as written, and all other control bits read 0.
- R7: `irq` equals the OR over bits 25..16 of (status AND control), sampled one clock earlier.
- R8: RX busy (status bit 29) sets at the edge after a lock pulse that arrives while RX enable is 1.
- R9: Once set, RX busy clears at the edge after an idle indication, or after a frame end seen while RX enable is 0. A frame end while RX enable is 1 leaves it set.
- R10: TX busy (status bit 28) is 1 at the edge after any cycle in which TX enable is 1. It clears only at the edge after a TX frame end seen while TX enable is 0.
- R11: A lock pulse while RX enable is 0 does not set RX busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register select: 0 control, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| ev_bad_pre | input | 1 | Pulse: bad or missing preamble |
| ev_b_pre | input | 1 | Pulse: block-start preamble seen |
| ev_blk_done | input | 1 | Pulse: full channel-status block received |
| ev_user_unit | input | 1 | Pulse: valid user-data unit received |
| lv_tx_under | input | 1 | Level: TX FIFO underrun |
| lv_rx_over | input | 1 | Level: RX FIFO overrun |
| lv_attn | input | 4 | Level: attention flags {RX user, TX user, RX data, TX data} |
| rx_lock | input | 1 | Pulse: receiver locked onto a preamble |
| rx_frame_end | input | 1 | Pulse: receive frame ended |
| rx_idle | input | 1 | Receive stream inactive |
| tx_frame_end | input | 1 | Pulse: transmit frame ended |
| irq | output | 1 | Registered interrupt request |

## Verification
A sticky flag that drops too early or fails to latch shows on the next status read. It also shows one cycle later on `irq` once that source is enabled. A wrong busy state shows at bit 29 or 28 one edge after the lock, idle or frame-end cycle that should have changed it, so the bench compares the full read word and `irq` on every cycle against its own cycle model. Random traffic mixes writes, event pulses and level changes, and directed sequences cover the set-wins collision, partial clears and each busy transition.

// File: rtl/audio_stat_pkg.sv
package audio_stat_pkg;

  localparam int WORD_W        = 32;
  localparam int N_STICKY      = 4;
  localparam int N_ATTN        = 4;

  localparam int POS_RX_BUSY   = 29;
  localparam int POS_TX_BUSY   = 28;
  localparam int POS_UNDER     = 25;
  localparam int POS_OVER      = 24;
  localparam int POS_STICKY_LO = 20;
  localparam int POS_ATTN_LO   = 16;
  localparam int POS_LOOP      = 15;
  localparam int POS_RX_EN     = 29;
  localparam int POS_TX_EN     = 28;
  localparam int IRQ_LO        = 16;
  localparam int IRQ_HI        = 25;
  localparam int IRQ_W         = IRQ_HI - IRQ_LO + 1;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  // Bits of the control register that software can write
  function automatic logic [WORD_W-1:0] ctrl_wr_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[POS_RX_EN] = 1'b1;
    m[POS_TX_EN] = 1'b1;
    for (int i = IRQ_LO; i <= IRQ_HI; i++) m[i] = 1'b1;
    m[POS_LOOP] = 1'b1;
    return m;
  endfunction

  // Assemble the status word from its live and stored parts
  function automatic logic [WORD_W-1:0] pack_status(
    input logic                rxb,
    input logic                txb,
    input logic                under,
    input logic                over,
    input logic [N_STICKY-1:0] sticky,
    input logic [N_ATTN-1:0]   attn
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[POS_RX_BUSY] = rxb;
    w[POS_TX_BUSY] = txb;
    w[POS_UNDER]   = under;
    w[POS_OVER]    = over;
    w[POS_STICKY_LO +: N_STICKY] = sticky;
    w[POS_ATTN_LO   +: N_ATTN]   = attn;
    return w;
  endfunction

  // OR of enabled interrupt sources
  function automatic logic irq_reduce(
    input logic [WORD_W-1:0] stat,
    input logic [WORD_W-1:0] ctrl
  );
    return |(stat[IRQ_HI:IRQ_LO] & ctrl[IRQ_HI:IRQ_LO]);
  endfunction

  // Next busy state: set by start, held until a stop condition
  function automatic logic busy_next(
    input logic busy,
    input logic start,
    input logic en,
    input logic frame_end,
    input logic idle
  );
    if (busy) return ~(idle | (~en & frame_end));
    return start;
  endfunction

endpackage

// File: rtl/stat_sticky_bank.sv
module stat_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)          q <= 1'b0;
      else if (set_i[g])   q <= 1'b1;
      else if (clr_i[g])   q <= 1'b0;
    end
    assign flag_o[g] = q;
  end

endmodule

// File: rtl/stat_busy_track.sv
module stat_busy_track
  import audio_stat_pkg::*;
#(
  parameter bit WAIT_LOCK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lock,
  input  logic frame_end,
  input  logic idle,
  output logic busy
);

  logic start;
  logic busy_d;

  assign start  = WAIT_LOCK ? (en & lock) : en;
  assign busy_d = busy_next(busy, start, en, frame_end, idle);

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end

endmodule

// File: rtl/stat_irq_merge.sv
module stat_irq_merge
  import audio_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] stat,
  input  logic [WORD_W-1:0] ctrl,
  output logic              irq_q
);

  logic irq_d;
  assign irq_d = irq_reduce(stat, ctrl);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/audio_stat_regs.sv
module audio_stat_regs
  import audio_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ev_bad_pre,
  input  logic              ev_b_pre,
  input  logic              ev_blk_done,
  input  logic              ev_user_unit,
  input  logic              lv_tx_under,
  input  logic              lv_rx_over,
  input  logic [N_ATTN-1:0] lv_attn,
  input  logic              rx_lock,
  input  logic              rx_frame_end,
  input  logic              rx_idle,
  input  logic              tx_frame_end,
  output logic              irq
);

  localparam logic [WORD_W-1:0] CTRL_MASK = ctrl_wr_mask();

  logic [WORD_W-1:0]   ctrl_q;
  logic [WORD_W-1:0]   stat_word;
  logic [N_STICKY-1:0] ev_vec;
  logic [N_STICKY-1:0] clr_mask;
  logic [N_STICKY-1:0] sticky_q;
  logic                wr_ctrl;
  logic                wr_stat;
  logic                rx_en;
  logic                tx_en;
  logic                rx_busy;
  logic                tx_busy;

  assign wr_ctrl  = bus_wr & (bus_sel == SEL_CTRL);
  assign wr_stat  = bus_wr & (bus_sel == SEL_STAT);
  assign ev_vec   = {ev_bad_pre, ev_b_pre, ev_blk_done, ev_user_unit};
  assign clr_mask = wr_stat ? bus_wdata[POS_STICKY_LO +: N_STICKY] : '0;
  assign rx_en    = ctrl_q[POS_RX_EN];
  assign tx_en    = ctrl_q[POS_TX_EN];

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
  end

  stat_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ev_vec),
    .clr_i  (clr_mask),
    .flag_o (sticky_q)
  );

  stat_busy_track #(.WAIT_LOCK(1'b1)) u_rx_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .lock      (rx_lock),
    .frame_end (rx_frame_end),
    .idle      (rx_idle),
    .busy      (rx_busy)
  );

  stat_busy_track #(.WAIT_LOCK(1'b0)) u_tx_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_en),
    .lock      (1'b0),
    .frame_end (tx_frame_end),
    .idle      (1'b0),
    .busy      (tx_busy)
  );

  assign stat_word = pack_status(rx_busy, tx_busy, lv_tx_under, lv_rx_over,
                                 sticky_q, lv_attn);

  stat_irq_merge u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (stat_word),
    .ctrl  (ctrl_q),
    .irq_q (irq)
  );

  assign bus_rdata = (bus_sel == SEL_STAT) ? stat_word : ctrl_q;

endmodule

// File: rtl/audio_stat_chk.sv
module audio_stat_chk
  import audio_stat_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [N_STICKY-1:0] sticky_q,
  input logic [N_STICKY-1:0] clr_mask,
  input logic [N_STICKY-1:0] ev_vec,
  input logic [WORD_W-1:0]   stat_word,
  input logic [WORD_W-1:0]   ctrl_q,
  input logic                irq,
  input logic                rx_busy,
  input logic                tx_busy,
  input logic                rx_idle
);

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sticky_q) & ~$past(clr_mask)) & ~sticky_q) == '0)); // R3

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_vec) & ~sticky_q) == '0)); // R4

  AST_IRQ_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(stat_word[IRQ_HI:IRQ_LO]) & $past(ctrl_q[IRQ_HI:IRQ_LO])))); // R7

  AST_TX_BUSY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[POS_TX_EN] |=> tx_busy); // R10

  AST_RX_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_busy && !ctrl_q[POS_RX_EN]) |=> !rx_busy); // R11

  AST_RX_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && rx_idle) |=> !rx_busy); // R9

  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~ctrl_wr_mask()) == '0); // R6

endmodule

bind audio_stat_regs audio_stat_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sticky_q  (sticky_q),
  .clr_mask  (clr_mask),
  .ev_vec    (ev_vec),
  .stat_word (stat_word),
  .ctrl_q    (ctrl_q),
  .irq       (irq),
  .rx_busy   (rx_busy),
  .tx_busy   (tx_busy),
  .rx_idle   (rx_idle)
);

// File: tb/sim_audio_stat_regs.sv
`timescale 1ns/1ps
module sim_audio_stat_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_bad_pre = 1'b0, ev_b_pre = 1'b0, ev_blk_done = 1'b0, ev_user_unit = 1'b0;
  logic        lv_tx_under = 1'b0, lv_rx_over = 1'b0;
  logic [3:0]  lv_attn = '0;
  logic        rx_lock = 1'b0, rx_frame_end = 1'b0, rx_idle = 1'b0, tx_frame_end = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // bench model state
  logic [3:0]  m_sticky = '0;
  logic [31:0] m_ctrl   = '0;
  logic        m_rxb = 1'b0, m_txb = 1'b0, m_irq = 1'b0;

  always #10 clk = ~clk;

  audio_stat_regs u0 (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_wdata, .bus_rdata,
    .ev_bad_pre, .ev_b_pre, .ev_blk_done, .ev_user_unit,
    .lv_tx_under, .lv_rx_over, .lv_attn,
    .rx_lock, .rx_frame_end, .rx_idle, .tx_frame_end, .irq
  );

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = 32'h0;
    s[29] = m_rxb;       s[28] = m_txb;
    s[25] = lv_tx_under; s[24] = lv_rx_over;
    s[23] = m_sticky[3]; s[22] = m_sticky[2];
    s[21] = m_sticky[1]; s[20] = m_sticky[0];
    s[19:16] = lv_attn;
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check, advance model, move to next negedge
  task automatic step(input string tag, input bit sel, input bit wr, input logic [31:0] wd,
                      input logic [3:0] ev, input bit und, input bit ovr, input logic [3:0] at,
                      input bit lck, input bit rfe, input bit idl, input bit tfe);
    logic [31:0] st;
    logic [3:0]  clr;
    logic        rx_on, tx_on;
    bus_sel = sel; bus_wr = wr; bus_wdata = wd;
    {ev_bad_pre, ev_b_pre, ev_blk_done, ev_user_unit} = ev;
    lv_tx_under = und; lv_rx_over = ovr; lv_attn = at;
    rx_lock = lck; rx_frame_end = rfe; rx_idle = idl; tx_frame_end = tfe;
    #1;
    st = exp_status();
    check(tag, bus_rdata, sel ? st : m_ctrl);
    check("R7", {31'b0, irq}, {31'b0, m_irq});
    clr   = (wr && sel) ? wd[23:20] : 4'b0;
    rx_on = m_ctrl[29];
    tx_on = m_ctrl[28];
    m_irq = (st[25:16] & m_ctrl[25:16]) != 10'b0;
    m_sticky = ev | (m_sticky & ~clr);
    if (m_rxb) m_rxb = !(idl || (!rx_on && rfe));
    else       m_rxb = rx_on && lck;
    m_txb = tx_on || (m_txb && !tfe);
    if (wr && !sel) m_ctrl = wd & 32'h33FF_8000;
    @(negedge clk);
  endtask

  task automatic idle_rd(input string tag, input bit sel);
    step(tag, sel, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr_reg(input string tag, input bit sel, input logic [31:0] d);
    step(tag, sel, 1'b1, d, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    idle_rd("R1", 1'b0);
    idle_rd("R1", 1'b1);
    // R2 events latch and hold
    step("R2", 1'b1, 1'b0, 32'h0, 4'b1010, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_rd("R2", 1'b1);
    idle_rd("R2", 1'b1);
    // R3 partial clear: bit 23 only
    wr_reg("R3", 1'b1, 32'h0080_0000);
    idle_rd("R3", 1'b1);
    // R4 collision on bit 21
    step("R4", 1'b1, 1'b1, 32'h0020_0000, 4'b0010, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_rd("R4", 1'b1);
    wr_reg("R3", 1'b1, 32'h0020_0000);
    idle_rd("R3", 1'b1);
    // R5 live levels, writes ignored
    step("R5", 1'b1, 1'b0, 32'h0, 4'h0, 1'b1, 1'b0, 4'b1011, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R5", 1'b1, 1'b1, 32'hFFFF_FFFF, 4'h0, 1'b0, 1'b1, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_rd("R5", 1'b1);
    // R6 control readback mask
    wr_reg("R6", 1'b0, 32'hFFFF_FFFF);
    idle_rd("R6", 1'b0);
    idle_rd("R10", 1'b1);
    wr_reg("R6", 1'b0, 32'h0000_0000);
    step("R10", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle_rd("R10", 1'b1);
    // R7 interrupt from B-preamble and from TX data attention
    wr_reg("R7", 1'b0, 32'h0041_0000);
    step("R7", 1'b1, 1'b0, 32'h0, 4'b0100, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_rd("R7", 1'b1);
    idle_rd("R7", 1'b1);
    wr_reg("R7", 1'b1, 32'h0040_0000);
    idle_rd("R7", 1'b1);
    step("R7", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_rd("R7", 1'b1);
    // R11 lock without enable
    wr_reg("R11", 1'b0, 32'h0);
    step("R11", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle_rd("R11", 1'b1);
    // R8 / R9 receive busy
    wr_reg("R8", 1'b0, 32'h2000_0000);
    step("R8", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R9", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    idle_rd("R9", 1'b1);
    wr_reg("R9", 1'b0, 32'h0);
    step("R9", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    idle_rd("R9", 1'b1);
    wr_reg("R9", 1'b0, 32'h2000_0000);
    step("R8", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R9", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    idle_rd("R9", 1'b1);
    // R10 transmit busy
    wr_reg("R10", 1'b0, 32'h1000_0000);
    step("R10", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    wr_reg("R10", 1'b0, 32'h0);
    idle_rd("R10", 1'b1);
    step("R10", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle_rd("R10", 1'b1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit          sel, wr;
      logic [31:0] wd;
      logic [3:0]  ev, at;
      sel = $urandom_range(0, 1);
      wr  = ($urandom_range(0, 5) == 0);
      wd  = $urandom();
      ev  = 4'($urandom()) & 4'($urandom()) & 4'($urandom());
      at  = 4'($urandom());
      step(sel ? "R2" : "R6", sel, wr, wd, ev,
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), at,
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 4) == 0));
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule